// File: doc/BRIEF.md
# Reversible One-Hot Address Decoder

This block turns an N-bit select word into 2^N one-hot decode lines. It uses only reversible primitives, so each gate has exactly as many outputs as inputs and maps its input patterns one-to-one onto its output patterns. There are two primitives. A two-line XOR gate copies or complements a bit. A three-line controlled-swap gate steers a data line onto one of two outputs under a control bit.

The tree grows one select bit at a time. The root stage is a single XOR gate. It is fed select bit 0 and a constant-one ancilla, so it yields that bit and its complement with no leftover line. Each later stage takes every line of the previous decoder into its own controlled-swap gate, together with the next select bit and a constant-zero ancilla. Each gate yields two new decode lines. The select bit passes from gate to gate along a chain. At the end of the chain it leaves the stage as that stage's single garbage line.

The top exposes every constant input and every garbage output on its ports. The whole circuit can therefore be checked as a square, one-to-one function. Callers tie the ancilla inputs to their constants and ignore the garbage lines.

Top module: `rev_decoder`

## Requirements
- R1: The XOR primitive maps (a, b) to (p, q) with p = a and q = a XOR b, and its four input patterns give four distinct output pairs.
- R2: The controlled-swap primitive maps (a, b, c) to (p, q, r) with p = a, q = (a ? b : c), r = (a ? c : b). With c = 0 this gives q = a AND b and r = (NOT a) AND b. Its eight input patterns give eight distinct output triples, and it keeps the number of ones unchanged.
- R3: With `anc_one_i` = 1 and `anc_zero_i` all zero, exactly one bit of `dec_o` is high, and that bit is at index `sel_i` (select bit 0 is the least significant).
- R4: The decoder has N-1 garbage lines, and `junk_o[k]` equals `sel_i[k+1]` for every k, whatever the ancilla inputs are.
- R5: The top has as many input bits as output bits (2^N + N - 1 each). Every distinct assignment of all its inputs, ancillas included, gives a distinct output vector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sel_i | input | N | Select word to decode |
| anc_one_i | input | 1 | Ancilla of the root stage, tie to 1 |
| anc_zero_i | input | 2^N-2 | Ancillas of the growth stages, tie to 0 |
| dec_o | output | 2^N | One-hot decode lines |
| junk_o | output | N-1 | Garbage lines (the select bits 1 to N-1 passed through) |

## Verification
Index order is the corner the bench hits hardest. A stage that swapped its two outputs, or placed the new select bit at the wrong weight, would still produce a one-hot vector, but at a mirrored or shuffled index. A sweep of all sixteen selects against a shift-based model exposes that. If the root gate were fed the wrong constant, or its output polarity were flipped, lines would pair with the complement of select bit 0. The sweep also catches a gate that dropped its passthrough, because the garbage lines would then stop tracking the upper select bits. Exhaustive sweeps check that no two patterns collide, over each primitive and over a two-bit decoder with its ancillas driven freely. Any primitive that lost information would show up there as two patterns with the same outputs.

// File: rtl/rev_pkg.sv
// Shared sizing helpers for the reversible decoder tree.
// Assumes select widths of at least 2.
package rev_pkg;

    // Number of decode lines for an n-bit select word.
    function automatic int line_count(input int n);
        return 1 << n;
    endfunction

    // Constant-zero ancillas: one per controlled-swap gate.
    function automatic int zero_count(input int n);
        return (1 << n) - 2;
    endfunction

    // Garbage lines: one per growth stage.
    function automatic int junk_count(input int n);
        return n - 1;
    endfunction

    // Total primitive gates in the tree.
    function automatic int gate_count(input int n);
        return (1 << n) - 1;
    endfunction

endpackage

// File: rtl/rev_cnot.sv
// Two-line reversible XOR gate: p copies a, q carries a XOR b.
// Purely combinational; it is its own inverse.
module rev_cnot (
    input  logic a_i,
    input  logic b_i,
    output logic p_o,
    output logic q_o
);

    // Forward mapping.
    always_comb begin
        p_o = a_i;
        q_o = a_i ^ b_i;
    end

    // Inverse check: both inputs are recoverable from the outputs.
    always_comb begin
        if (!$isunknown({a_i, b_i, p_o, q_o})) begin
            assert_cnot_invert_R1: assert (p_o == a_i && (p_o ^ q_o) == b_i)
                else $error("xor gate outputs do not invert to its inputs");
        end
    end

endmodule

// File: rtl/rev_cswap.sv
// Three-line reversible steering gate. The control a passes through.
// When a is 1, b goes to q and c goes to r; when a is 0 they cross.
// With c tied to 0 this yields q = a&b and r = ~a&b.
module rev_cswap (
    input  logic a_i,
    input  logic b_i,
    input  logic c_i,
    output logic p_o,
    output logic q_o,
    output logic r_o
);

    // Forward mapping.
    always_comb begin
        p_o = a_i;
        q_o = a_i ? b_i : c_i;
        r_o = a_i ? c_i : b_i;
    end

    // Inverse and weight checks on the settled outputs.
    always_comb begin
        if (!$isunknown({a_i, b_i, c_i, p_o, q_o, r_o})) begin
            assert_cswap_invert_R2: assert ((p_o ? q_o : r_o) == b_i &&
                                            (p_o ? r_o : q_o) == c_i)
                else $error("steering gate outputs do not invert to its inputs");
            assert_cswap_weight_R2: assert ($countones({p_o, q_o, r_o}) ==
                                            $countones({a_i, b_i, c_i}))
                else $error("steering gate changed the number of ones");
        end
    end

endmodule

// File: rtl/rev_dec_stage.sv
// One growth stage of the decoder. It takes W lines of a smaller decoder and
// one new select bit and makes 2W lines. Gate j steers line j to output
// j + W when the select bit is 1 and to output j when it is 0. The select
// bit is chained through the gates' passthrough outputs, so the chain end
// ctl_o is the stage's single garbage line. Assumes zero_i is tied to 0
// for decode use.
module rev_dec_stage #(
    parameter int W = 2
) (
    input  logic           ctl_i,
    input  logic [W-1:0]   prev_i,
    input  logic [W-1:0]   zero_i,
    output logic [2*W-1:0] next_o,
    output logic           ctl_o
);

    logic [W:0] chain;

    // Head of the control chain.
    assign chain[0] = ctl_i;

    // One steering gate per incoming line.
    for (genvar j = 0; j < W; j++) begin : g_gate
        rev_cswap u_cswap (
            .a_i (chain[j]),
            .b_i (prev_i[j]),
            .c_i (zero_i[j]),
            .p_o (chain[j+1]),
            .q_o (next_o[j+W]),
            .r_o (next_o[j])
        );
    end

    // Tail of the chain leaves as garbage.
    assign ctl_o = chain[W];

    // The control bit must reach the end of the chain unchanged.
    always_comb begin
        if (!$isunknown({ctl_i, ctl_o})) begin
            assert_stage_chain_R4: assert (ctl_o == ctl_i)
                else $error("select bit altered along the stage chain");
        end
    end

endmodule

// File: rtl/rev_decoder.sv
// N-to-2^N one-hot decoder built only from reversible gates.
// Stage 0 is one XOR gate fed by sel_i[0] and anc_one_i. Stage k (k >= 1)
// doubles the line count under sel_i[k]. All stage lines are packed into
// one vector: stage k occupies 2^(k+1) bits starting at 2^(k+1) - 2.
// Assumes N >= 2 and, for decoding, anc_one_i = 1 and anc_zero_i = 0.
module rev_decoder #(
    parameter int N = 4
) (
    input  logic [N-1:0]                    sel_i,
    input  logic                            anc_one_i,
    input  logic [rev_pkg::zero_count(N)-1:0] anc_zero_i,
    output logic [rev_pkg::line_count(N)-1:0] dec_o,
    output logic [rev_pkg::junk_count(N)-1:0] junk_o
);

    localparam int L  = rev_pkg::line_count(N);
    localparam int AW = 2 * L - 2;

    logic [AW-1:0] all_lines;

    // Build the tree stage by stage.
    for (genvar k = 0; k < N; k++) begin : g_stg
        localparam int W = 1 << k;
        if (k == 0) begin : g_root
            rev_cnot u_root (
                .a_i (sel_i[0]),
                .b_i (anc_one_i),
                .p_o (all_lines[1]),
                .q_o (all_lines[0])
            );
        end else begin : g_grow
            rev_dec_stage #(.W(W)) u_stage (
                .ctl_i  (sel_i[k]),
                .prev_i (all_lines[W-2 +: W]),
                .zero_i (anc_zero_i[W-2 +: W]),
                .next_o (all_lines[2*W-2 +: 2*W]),
                .ctl_o  (junk_o[k-1])
            );
        end
    end

    // The last stage's lines are the decode outputs.
    assign dec_o = all_lines[L-2 +: L];

    // Decode and garbage properties at the top ports.
    always_comb begin
        if (!$isunknown({sel_i, anc_one_i, anc_zero_i, dec_o, junk_o})) begin
            if (anc_one_i && anc_zero_i == '0) begin
                assert_onehot_R3: assert ($onehot(dec_o))
                    else $error("decode lines not one-hot");
                assert_index_R3: assert (dec_o[sel_i])
                    else $error("active decode line not at select index");
            end
            assert_junk_R4: assert (junk_o == sel_i[N-1:1])
                else $error("garbage lines do not carry the upper select bits");
        end
    end

endmodule

// File: tb/rev_decoder_bench.sv
// Bench: sweeps each primitive, the 4-bit decoder and a 2-bit decoder with
// free ancillas, comparing against a behavioural model at each clock.
module rev_decoder_bench;

    logic clk = 1'b0;
    logic rst_n;
    always #2 clk = ~clk;

    int  checks = 0;
    int  errors = 0;
    bit  done   = 1'b0;

    // Primitive instances.
    logic ca, cb, cp, cq;
    logic sa, sb, sc, sp, sq, sr;
    rev_cnot  u_cnot  (.a_i(ca), .b_i(cb), .p_o(cp), .q_o(cq));
    rev_cswap u_cswap (.a_i(sa), .b_i(sb), .c_i(sc), .p_o(sp), .q_o(sq), .r_o(sr));

    // Default-size decoder.
    logic [3:0]  sel4;
    logic        one4;
    logic [13:0] zero4;
    logic [15:0] dec4;
    logic [2:0]  junk4;
    rev_decoder #(.N(4)) u_rev_decoder (
        .sel_i(sel4), .anc_one_i(one4), .anc_zero_i(zero4),
        .dec_o(dec4), .junk_o(junk4));

    // Small decoder for the exhaustive one-to-one sweep.
    logic [1:0] sel2;
    logic       one2;
    logic [1:0] zero2;
    logic [3:0] dec2;
    logic [0:0] junk2;
    rev_decoder #(.N(2)) u_rev_decoder_small (
        .sel_i(sel2), .anc_one_i(one2), .anc_zero_i(zero2),
        .dec_o(dec2), .junk_o(junk2));

    task automatic check(input bit ok, input string tag,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    // Watchdog.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog all-requirements actual=timeout expected=completion");
            finish_run();
        end
    end

    // Stimulus and checking.
    initial begin
        logic [1:0] seen_c [4];
        logic [2:0] seen_s [8];
        logic [4:0] seen_t [32];
        rst_n = 1'b0;
        {ca, cb} = 2'b00;
        {sa, sb, sc} = 3'b000;
        sel4 = '0; one4 = 1'b1; zero4 = '0;
        sel2 = '0; one2 = 1'b1; zero2 = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(dec4 == 16'h0001, "R3 reset state", dec4, 16'h0001);
        check(junk4 == 3'b000, "R4 reset state", junk4, 3'b000);
        rst_n = 1'b1;

        // R1: xor primitive map and distinctness.
        for (int i = 0; i < 4; i++) begin
            @(posedge clk);
            {ca, cb} = 2'(i);
            @(negedge clk);
            check({cp, cq} == {ca, ca ^ cb}, "R1 xor map", {cp, cq}, {ca, ca ^ cb});
            seen_c[i] = {cp, cq};
        end
        for (int i = 0; i < 4; i++)
            for (int j = i + 1; j < 4; j++)
                check(seen_c[i] != seen_c[j], "R1 xor distinct", seen_c[i], seen_c[j]);

        // R2: steering primitive map, weight and distinctness.
        for (int i = 0; i < 8; i++) begin
            logic [2:0] exp_s;
            @(posedge clk);
            {sa, sb, sc} = 3'(i);
            @(negedge clk);
            exp_s = {sa, (sa ? sb : sc), (sa ? sc : sb)};
            check({sp, sq, sr} == exp_s, "R2 steer map", {sp, sq, sr}, exp_s);
            if (!sc)
                check(sq == (sa & sb) && sr == (!sa & sb), "R2 steer zero-ancilla",
                      {sq, sr}, {sa & sb, !sa & sb});
            check($countones({sp, sq, sr}) == $countones(i[2:0]), "R2 steer weight",
                  $countones({sp, sq, sr}), $countones(i[2:0]));
            seen_s[i] = {sp, sq, sr};
        end
        for (int i = 0; i < 8; i++)
            for (int j = i + 1; j < 8; j++)
                check(seen_s[i] != seen_s[j], "R2 steer distinct", seen_s[i], seen_s[j]);

        // R3/R4: full select sweep on the default decoder.
        for (int s = 0; s < 16; s++) begin
            @(posedge clk);
            sel4 = 4'(s);
            @(negedge clk);
            check(dec4 == (16'd1 << s), "R3 decode", dec4, 16'd1 << s);
            check(junk4 == sel4[3:1], "R4 garbage", junk4, sel4[3:1]);
        end

        // R5: square width and one-to-one mapping on the small decoder.
        check($bits({dec2, junk2}) == $bits({sel2, one2, zero2}), "R5 width",
              $bits({dec2, junk2}), $bits({sel2, one2, zero2}));
        for (int p = 0; p < 32; p++) begin
            @(posedge clk);
            {sel2, one2, zero2} = 5'(p);
            @(negedge clk);
            check(junk2[0] == sel2[1], "R4 garbage free ancilla", junk2, sel2[1]);
            seen_t[p] = {dec2, junk2};
        end
        for (int i = 0; i < 32; i++)
            for (int j = i + 1; j < 32; j++)
                check(seen_t[i] != seen_t[j], "R5 distinct", seen_t[i], seen_t[j]);

        finish_run();
    end

endmodule